// File: doc/BRIEF.md
# Hamming Best-Match Pattern Classifier

This block takes one 128-bit vector of two-level samples and finds which of a bank of stored 128-bit templates it resembles most. Similarity is the number of bit positions in which the sample vector and a template agree, which equals the number of zero bits in their XOR. The block reports the index of the most similar template together with that agreement count.

Templates are loaded through a simple write port before a search. A search starts with a one-cycle `start` pulse that also captures the sample vector and the number of templates to consider. The block then walks the bank one template at a time. It consumes one byte of the XOR per clock and converts that byte to its zero count through a 256-entry table. After the sixteenth byte it spends one cycle on a compare step that keeps the running best.

The controller has four states. `ST_IDLE` waits for `start`. `ST_ACCUM` adds one byte's zero count per cycle. `ST_COMPARE` updates the leader and steps to the next template. `ST_FINISH` raises `done` for one cycle.

The transitions are as follows. `ST_IDLE` moves to `ST_ACCUM` on an accepted start, or to `ST_FINISH` when the effective count is zero. `ST_ACCUM` stays put until the last byte and then moves to `ST_COMPARE`. `ST_COMPARE` returns to `ST_ACCUM` for the next template, or moves to `ST_FINISH` after the last one. `ST_FINISH` always returns to `ST_IDLE`.

Top module: `hbm_classifier`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `best_idx` and `best_score` are all 0.
- R2: The score of template i is the number of positions where the latched query and template i hold the same bit value, from 0 to 128. `best_score` reports the score of the winning template.
- R3: The winner is the template with the highest score among indices 0 to N-1, where N is the effective active count. Templates at index N or above take no part in the search.
- R4: When several templates share the highest score, the lowest index among them is reported.
- R5: With N effective templates, `done` is high for exactly one cycle. That cycle begins 17*N clock edges after the edge that accepted `start`. `busy` is high from the cycle after the accepting edge through the `done` cycle, and low the cycle after.
- R6: A `start` pulse while `busy` is high has no effect: latency and result stay those of the search in progress.
- R7: The query and the active count are captured on the accepting edge. Later changes of `query` do not alter the result.
- R8: An `active_cnt` greater than `NUM_PAT` is treated as `NUM_PAT`.
- R9: An `active_cnt` of 0 gives `done` in the cycle right after the accepting edge, with `best_idx` = 0 and `best_score` = 0.
- R10: A cycle with `wr_en` high stores `wr_data` as template `wr_addr`, and the next search uses the new contents.
- R11: `best_idx` and `best_score` change only at the edge that starts the `done` cycle, and then hold until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Template write enable |
| wr_addr | input | IDX_W (6) | Template index to write |
| wr_data | input | VEC_W (128) | Template contents |
| query | input | VEC_W (128) | Sample vector, captured at start |
| active_cnt | input | CNT_W (6) | Number of templates to search |
| start | input | 1 | One-cycle search request, accepted only when idle |
| busy | output | 1 | Search in progress (including done cycle) |
| done | output | 1 | One-cycle completion pulse |
| best_idx | output | IDX_W (6) | Index of best template |
| best_score | output | SCORE_W (8) | Agreement count of best template |

## Verification
The bench builds the block with its default sizes: 128-bit vectors and a 40-entry bank. With these sizes the full-bank latency of 680 cycles is measured directly. An `active_cnt` of 63 exercises the clamp to 40, and every score from 0 to 128 can be produced, including the 128 and 0 extremes used for the tie checks. Random templates and queries drawn from a fixed seed cover ordinary score spreads. Directed cases place exact copies and complements of the query in the bank, overwrite entries, and pulse `start` or change `query` in the middle of a search.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_COMPARE = 2'd2,
        ST_FINISH  = 2'd3
    } hbm_state_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/hbm_pattern_bank.sv
module hbm_pattern_bank #(
    parameter int unsigned VEC_W   = 128,
    parameter int unsigned NUM_PAT = 40,
    parameter int unsigned IDX_W   = $clog2(NUM_PAT)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [VEC_W-1:0] rd_data
);

    logic [VEC_W-1:0] store_q [NUM_PAT];

    // writes to indices beyond the bank are dropped
    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_addr} < (IDX_W+1)'(NUM_PAT))) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/hbm_zero_lut.sv
module hbm_zero_lut #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned CNT_W  = $clog2(LANE_W + 1)
) (
    input  logic [LANE_W-1:0] lane,
    output logic [CNT_W-1:0]  zeros
);

    localparam int unsigned ENTRIES = 1 << LANE_W;

    function automatic logic [CNT_W-1:0] count_zeros(input logic [LANE_W-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int b = 0; b < LANE_W; b++) begin
            if (!v[b]) c = c + 1'b1;
        end
        return c;
    endfunction

    logic [CNT_W-1:0] table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_w[g] = count_zeros(LANE_W'(g));
    end

    assign zeros = table_w[lane];

endmodule

// File: rtl/hbm_argmax.sv
module hbm_argmax #(
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned SCORE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               cmp_en,
    input  logic [IDX_W-1:0]   cand_idx,
    input  logic [SCORE_W-1:0] cand_score,
    output logic [IDX_W-1:0]   lead_idx,
    output logic [SCORE_W-1:0] lead_score
);

    logic               have_q;
    logic [IDX_W-1:0]   idx_q;
    logic [SCORE_W-1:0] score_q;
    logic               take;

    // strict greater-than keeps the earlier (lower) index on ties
    assign take       = !have_q || (cand_score > score_q);
    assign lead_idx   = take ? cand_idx   : idx_q;
    assign lead_score = take ? cand_score : score_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_q  <= 1'b0;
            idx_q   <= '0;
            score_q <= '0;
        end else if (cmp_en && take) begin
            have_q  <= 1'b1;
            idx_q   <= cand_idx;
            score_q <= cand_score;
        end
    end

endmodule

// File: rtl/hbm_classifier.sv
module hbm_classifier
    import hbm_pkg::*;
#(
    parameter int unsigned VEC_W   = 128,
    parameter int unsigned NUM_PAT = 40,
    parameter int unsigned IDX_W   = $clog2(NUM_PAT),
    parameter int unsigned CNT_W   = $clog2(NUM_PAT + 1),
    parameter int unsigned SCORE_W = $clog2(VEC_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic [VEC_W-1:0]   query,
    input  logic [CNT_W-1:0]   active_cnt,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   best_idx,
    output logic [SCORE_W-1:0] best_score
);

    localparam int unsigned NLANES = VEC_W / LANE_W;
    localparam int unsigned LSEL_W = (NLANES > 1) ? $clog2(NLANES) : 1;
    localparam int unsigned ZC_W   = $clog2(LANE_W + 1);

    hbm_state_e state_q, state_d;

    logic [VEC_W-1:0]   query_q;
    logic [CNT_W-1:0]   count_q;
    logic [IDX_W-1:0]   pat_q;
    logic [LSEL_W-1:0]  lane_q;
    logic [SCORE_W-1:0] acc_q;
    logic [IDX_W-1:0]   res_idx_q;
    logic [SCORE_W-1:0] res_score_q;

    logic               accept;
    logic [CNT_W-1:0]   count_eff;
    logic               last_lane;
    logic               last_pat;
    logic [VEC_W-1:0]   tmpl;
    logic [VEC_W-1:0]   diff;
    logic [LANE_W-1:0]  lane_bits;
    logic [ZC_W-1:0]    lane_zeros;
    logic [IDX_W-1:0]   lead_idx;
    logic [SCORE_W-1:0] lead_score;

    assign accept    = start && (state_q == ST_IDLE);
    assign count_eff = (active_cnt > CNT_W'(NUM_PAT)) ? CNT_W'(NUM_PAT) : active_cnt;
    assign last_lane = (lane_q == LSEL_W'(NLANES - 1));
    assign last_pat  = (CNT_W'(pat_q) == (count_q - 1'b1));

    hbm_pattern_bank #(
        .VEC_W   (VEC_W),
        .NUM_PAT (NUM_PAT),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (pat_q),
        .rd_data (tmpl)
    );

    assign diff      = query_q ^ tmpl;
    assign lane_bits = diff[int'(lane_q)*LANE_W +: LANE_W];

    hbm_zero_lut #(
        .LANE_W (LANE_W),
        .CNT_W  (ZC_W)
    ) u_lut (
        .lane  (lane_bits),
        .zeros (lane_zeros)
    );

    hbm_argmax #(
        .IDX_W   (IDX_W),
        .SCORE_W (SCORE_W)
    ) u_argmax (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .cmp_en     (state_q == ST_COMPARE),
        .cand_idx   (pat_q),
        .cand_score (acc_q),
        .lead_idx   (lead_idx),
        .lead_score (lead_score)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (count_eff == '0) ? ST_FINISH : ST_ACCUM;
            end
            ST_ACCUM: begin
                if (last_lane) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                state_d = last_pat ? ST_FINISH : ST_ACCUM;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // search datapath: captured operands, walk pointers, accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            query_q <= '0;
            count_q <= '0;
            pat_q   <= '0;
            lane_q  <= '0;
            acc_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        query_q <= query;
                        count_q <= count_eff;
                        pat_q   <= '0;
                        lane_q  <= '0;
                        acc_q   <= '0;
                    end
                end
                ST_ACCUM: begin
                    acc_q  <= acc_q + SCORE_W'(lane_zeros);
                    lane_q <= lane_q + 1'b1;
                end
                ST_COMPARE: begin
                    acc_q  <= '0;
                    lane_q <= '0;
                    if (!last_pat) pat_q <= pat_q + 1'b1;
                end
                ST_FINISH: begin
                    lane_q <= '0;
                end
                default: begin
                    lane_q <= '0;
                end
            endcase
        end
    end

    // published results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_idx_q   <= '0;
            res_score_q <= '0;
        end else if (accept && (count_eff == '0)) begin
            res_idx_q   <= '0;
            res_score_q <= '0;
        end else if ((state_q == ST_COMPARE) && last_pat) begin
            res_idx_q   <= lead_idx;
            res_score_q <= lead_score;
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        best_idx   = res_idx_q;
        best_score = res_score_q;
    end

endmodule

// File: rtl/hbm_classifier_chk.sv
module hbm_classifier_chk #(
    parameter int unsigned VEC_W   = 128,
    parameter int unsigned NUM_PAT = 40,
    parameter int unsigned IDX_W   = $clog2(NUM_PAT),
    parameter int unsigned CNT_W   = $clog2(NUM_PAT + 1),
    parameter int unsigned SCORE_W = $clog2(VEC_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [CNT_W-1:0]   active_cnt,
    input logic               busy,
    input logic               done,
    input logic [IDX_W-1:0]   best_idx,
    input logic [SCORE_W-1:0] best_score
);

    // R5: done lasts a single cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done is only seen while busy
    a_r5_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R6: a start during a search does not end it
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R9: zero count finishes right away
    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (active_cnt == '0)) |=> done);

    // R11: results hold outside the done cycle
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_idx) && $stable(best_score)));

    // R2: score never exceeds vector width
    a_r2_score_range: assert property (@(posedge clk) disable iff (!rst_n)
        best_score <= SCORE_W'(VEC_W));

    // R3: reported index lies inside the bank
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, best_idx} < (IDX_W+1)'(NUM_PAT));

endmodule

bind hbm_classifier hbm_classifier_chk #(
    .VEC_W   (VEC_W),
    .NUM_PAT (NUM_PAT),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .SCORE_W (SCORE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .active_cnt (active_cnt),
    .busy       (busy),
    .done       (done),
    .best_idx   (best_idx),
    .best_score (best_score)
);

// File: tb/hbm_classifier_tb.sv
`timescale 1ns/1ps
module hbm_classifier_tb;

    localparam int VEC_W   = 128;
    localparam int NUM_PAT = 40;
    localparam int IDX_W   = $clog2(NUM_PAT);
    localparam int CNT_W   = $clog2(NUM_PAT + 1);
    localparam int SCORE_W = $clog2(VEC_W + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [IDX_W-1:0]   wr_addr = '0;
    logic [VEC_W-1:0]   wr_data = '0;
    logic [VEC_W-1:0]   query = '0;
    logic [CNT_W-1:0]   active_cnt = '0;
    logic               start = 1'b0;
    logic               busy;
    logic               done;
    logic [IDX_W-1:0]   best_idx;
    logic [SCORE_W-1:0] best_score;

    int n_checks = 0;
    int n_fails  = 0;
    logic [VEC_W-1:0] model [NUM_PAT];

    always #4 clk = ~clk;

    hbm_classifier #(
        .VEC_W   (VEC_W),
        .NUM_PAT (NUM_PAT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .query      (query),
        .active_cnt (active_cnt),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .best_idx   (best_idx),
        .best_score (best_score)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int agree(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        int c = 0;
        for (int i = 0; i < VEC_W; i++) if (a[i] == b[i]) c++;
        return c;
    endfunction

    function automatic void expect_best(input logic [VEC_W-1:0] q, input int n,
                                        output int eidx, output int escore);
        eidx = 0;
        escore = (n == 0) ? 0 : -1;
        for (int i = 0; i < n; i++) begin
            int s = agree(q, model[i]);
            if (s > escore) begin escore = s; eidx = i; end
        end
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int w = 0; w < VEC_W/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic write_pat(input int idx, input logic [VEC_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDX_W'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = v;
    endtask

    task automatic run_search(input logic [VEC_W-1:0] q, input int n,
                              input bit poke_start, input bit poke_query,
                              input string req);
        int neff, eidx, escore, cyc;
        neff = (n > NUM_PAT) ? NUM_PAT : n;
        expect_best(q, neff, eidx, escore);
        @(negedge clk);
        query = q; active_cnt = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            if (cyc == 1) chk(busy == 1'b1, "R5", "busy mid-search", busy, 1);
            if (poke_start && cyc == 3) begin
                start = 1'b1; active_cnt = CNT_W'(1); query = ~q;     // R6 stimulus
            end else begin
                start = 1'b0;
            end
            if (poke_query && cyc == 5) query = ~q;                   // R7 stimulus
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == 17*neff, "R5", "done latency", cyc, 17*neff);
        chk(best_idx == IDX_W'(eidx), req, "best_idx", best_idx, eidx);
        chk(best_score == SCORE_W'(escore), req, "best_score", best_score, escore);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done width", done, 0);
        chk(busy == 1'b0, "R5", "busy after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] q;
        int keep_idx, keep_score;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(best_idx == '0, "R1", "best_idx in reset", best_idx, 0);
        chk(best_score == '0, "R1", "best_score in reset", best_score, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);

        for (int i = 0; i < NUM_PAT; i++) write_pat(i, rnd_vec());

        // R2 / R3: random queries and random active counts
        for (int t = 0; t < 6; t++) begin
            run_search(rnd_vec(), $urandom_range(NUM_PAT, 1), 1'b0, 1'b0, "R2_R3");
        end

        // R3: entries beyond the count are excluded (exact copy at index 30, N=20)
        q = rnd_vec();
        write_pat(30, q);
        run_search(q, 20, 1'b0, 1'b0, "R3");
        chk(best_score != SCORE_W'(VEC_W), "R3", "excluded entry not matched",
            best_score, 0);

        // R4: ties resolve to the lowest index (copies at 5 and 9)
        q = rnd_vec();
        write_pat(5, q);
        write_pat(9, q);
        run_search(q, NUM_PAT, 1'b0, 1'b0, "R4");

        // R2 / R4: all templates the complement of the query, score 0 at index 0
        q = rnd_vec();
        for (int i = 0; i < NUM_PAT; i++) write_pat(i, ~q);
        run_search(q, NUM_PAT, 1'b0, 1'b0, "R4");

        for (int i = 0; i < NUM_PAT; i++) write_pat(i, rnd_vec());

        // R8: oversize count clamped
        run_search(rnd_vec(), 63, 1'b0, 1'b0, "R8");

        // R9: zero count
        run_search(rnd_vec(), 8, 1'b0, 1'b0, "R9_pre");
        run_search(rnd_vec(), 0, 1'b0, 1'b0, "R9");

        // R6: start while busy
        run_search(rnd_vec(), 12, 1'b1, 1'b0, "R6");

        // R7: query changes mid-search
        run_search(rnd_vec(), 25, 1'b0, 1'b1, "R7");

        // R10: overwrite an entry with the query
        q = rnd_vec();
        write_pat(3, q);
        run_search(q, NUM_PAT, 1'b0, 1'b0, "R10");
        chk(best_idx == IDX_W'(3), "R10", "overwritten entry wins", best_idx, 3);

        // R11: results hold while idle
        keep_idx = int'(best_idx);
        keep_score = int'(best_score);
        repeat (10) @(negedge clk);
        chk(best_idx == IDX_W'(keep_idx), "R11", "idx held", best_idx, keep_idx);
        chk(best_score == SCORE_W'(keep_score), "R11", "score held", best_score, keep_score);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule